// File: doc/BRIEF.md
# Framer Loopback Path Router

This block is the steering fabric for one channel of a T1/E1 framer datapath. It sits between the stage outputs of the receive and transmit chains and the stage inputs they feed. Six loopback enables choose whether each stage input takes its normal upstream source or a loopback source. Every loopback keeps one direction running and replaces the data of the other. The elastic store, the jitter attenuators, the framer and the line interface are outside the block. Each one appears only as a stream port. A stream is packed as `{valid, sig[GW-1:0], data[DW-1:0]}`.

The two system-side loopbacks are legal only in certain clocking and rate modes. A request made outside those modes is dropped, and it sets a sticky error flag. While a system loopback is active, the system clock and frame pulse are copied from the master interface to the slave interface. An enable change takes effect only on a clock edge that carries the frame-boundary strobe of the path whose input it replaces. This keeps partial frames from being spliced. When two active enables drive the transmit payload input, a conflict flag is raised. In that case the system-side source wins.

Top module: `lbk_router`

## Requirements
- R1: After reset no loopback is active. The outputs are `rsys_o`=`es_i`, `tpc_o`=`tsys_i`, `fp_o`=`rja_q_i`, `tja_d_o`=`tbuf_i` and `rja_d_o`=`line_rx_i`, with `sys_err_o`=0 and `conflict_o`=0.
- R2: With system remote loopback active (`req_i[0]`), `rsys_o` carries `tsys_i` and `tpc_o` still carries `tsys_i`.
- R3: With system local loopback active (`req_i[1]`), `tpc_o` carries `es_i` and `rsys_o` still carries `es_i`.
- R4: A system loopback request (`req_i[0]` or `req_i[1]`) takes effect only under all of these conditions: both `rx_mux_i` and `tx_mux_i` are 0, exactly one of `rx_master_i`/`tx_master_i` is 1, and both `rx_e1r_i` and `tx_e1r_i` are 0. Otherwise the request is ignored.
- R5: On every clock edge where a system loopback request is present under an illegal mode, `sys_err_o` is set to 1. It stays 1 until a clock edge with `err_clr_i`=1 and no illegal request, and then it returns to 0.
- R6: While a system loopback is active, the master side's clock and frame pulse are copied to the slave side's outputs. With `rx_master_i`=1, `tx_sck_o`/`tx_sfs_o` follow `rx_sck_i`/`rx_sfs_i`. With `tx_master_i`=1, `rx_sck_o`/`rx_sfs_o` follow `tx_sck_i`/`tx_sfs_i`. In every other case each output follows its own input.
- R7: With payload loopback active (`req_i[2]`), `tpc_o` carries `es_i` and `rsys_o` still carries `es_i`.
- R8: With local digital loopback 1 active (`req_i[3]`), `fp_o` carries `tbuf_i` and `tja_d_o` still carries `tbuf_i`.
- R9: With remote loopback active (`req_i[4]`), `tja_d_o` carries `rja_q_i` and `fp_o` still carries `rja_q_i`.
- R10: With local digital loopback 2 active (`req_i[5]`), `rja_d_o` carries `tja_q_i` and `tja_d_o` still carries `tbuf_i`.
- R11: Enables `req_i[0]`, `req_i[3]` and `req_i[5]` are taken in only on a clock edge with `rx_fb_i`=1. Enables `req_i[1]`, `req_i[2]` and `req_i[4]` are taken in only on a clock edge with `tx_fb_i`=1. At other edges the active set holds.
- R12: When payload loopback and system local loopback are both active, `conflict_o` is 1 and `tpc_o` carries `es_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 6 | Requested loopback enables (bit map in R2–R11) |
| rx_fb_i | input | 1 | Receive-path frame boundary strobe |
| tx_fb_i | input | 1 | Transmit-path frame boundary strobe |
| rx_master_i | input | 1 | Receive system interface is clock master |
| tx_master_i | input | 1 | Transmit system interface is clock master |
| rx_mux_i | input | 1 | Receive system interface in multiplexed mode |
| tx_mux_i | input | 1 | Transmit system interface in multiplexed mode |
| rx_e1r_i | input | 1 | Receive path runs T1/J1 framing at the E1 rate |
| tx_e1r_i | input | 1 | Transmit path runs T1/J1 framing at the E1 rate |
| err_clr_i | input | 1 | Write-one clear of the sticky error |
| es_i | input | DW+GW+1 | Elastic store output stream |
| tsys_i | input | DW+GW+1 | System transmit input stream |
| line_rx_i | input | DW+GW+1 | Line receive stream |
| rja_q_i | input | DW+GW+1 | Receive jitter attenuator output |
| tbuf_i | input | DW+GW+1 | Transmit buffer output |
| tja_q_i | input | DW+GW+1 | Transmit jitter attenuator output |
| rsys_o | output | DW+GW+1 | Receive system output stream |
| tpc_o | output | DW+GW+1 | Transmit payload control input |
| fp_o | output | DW+GW+1 | Frame processor input |
| tja_d_o | output | DW+GW+1 | Transmit jitter attenuator input |
| rja_d_o | output | DW+GW+1 | Receive jitter attenuator input |
| rx_sck_i | input | 1 | Receive interface system clock |
| rx_sfs_i | input | 1 | Receive interface frame pulse |
| tx_sck_i | input | 1 | Transmit interface system clock |
| tx_sfs_i | input | 1 | Transmit interface frame pulse |
| rx_sck_o | output | 1 | Steered receive interface clock |
| rx_sfs_o | output | 1 | Steered receive interface frame pulse |
| tx_sck_o | output | 1 | Steered transmit interface clock |
| tx_sfs_o | output | 1 | Steered transmit interface frame pulse |
| sys_err_o | output | 1 | Sticky illegal system loopback request |
| conflict_o | output | 1 | Two active enables drive one stage input |

## Verification
The only state in the block is the registered active-enable set and the sticky error bit. A wrong bit in the active set shows up in the first sample after the clock edge that latched it, as a stage output carrying the wrong source stream. Each stream input carries a distinct constant, so the wrong source can be identified directly. A boundary strobe applied to the wrong path group shows as an output that switches one frame early or stays stale. The tests toggle one strobe at a time to expose that. A lost or falsely cleared error bit is visible at `sys_err_o` on the edge after the illegal request or the clear.

// File: rtl/lbk_pkg.sv
package lbk_pkg;
  // loopback enable bit positions
  localparam int unsigned LB_SRMT = 0;
  localparam int unsigned LB_SLOC = 1;
  localparam int unsigned LB_PAY  = 2;
  localparam int unsigned LB_DIG1 = 3;
  localparam int unsigned LB_REM  = 4;
  localparam int unsigned LB_DIG2 = 5;
  localparam int unsigned LB_N    = 6;

  // enables whose replaced input lies on the receive path
  localparam logic [LB_N-1:0] RX_GRP  = 6'b101001;
  // enables that need legal system clocking
  localparam logic [LB_N-1:0] SYS_GRP = 6'b000011;

  typedef enum logic [1:0] {
    STEER_NONE  = 2'd0,
    STEER_RX2TX = 2'd1,
    STEER_TX2RX = 2'd2
  } steer_e;
endpackage

// File: rtl/lbk_ctrl.sv
module lbk_ctrl
  import lbk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LB_N-1:0] req_i,
  input  logic            rx_fb_i,
  input  logic            tx_fb_i,
  input  logic            rx_master_i,
  input  logic            tx_master_i,
  input  logic            rx_mux_i,
  input  logic            tx_mux_i,
  input  logic            rx_e1r_i,
  input  logic            tx_e1r_i,
  input  logic            err_clr_i,
  output logic [LB_N-1:0] act_o,
  output logic            sys_ok_o,
  output logic            err_o,
  output logic            conflict_o
);
  logic            sys_ok;
  logic [LB_N-1:0] legal_mask;
  logic [LB_N-1:0] act_q, act_d;
  logic            act_en;
  logic            err_q, err_d, err_set;

  assign sys_ok     = ~rx_mux_i & ~tx_mux_i & (rx_master_i ^ tx_master_i)
                    & ~rx_e1r_i & ~tx_e1r_i;
  assign legal_mask = sys_ok ? {LB_N{1'b1}} : ~SYS_GRP;
  assign act_en     = rx_fb_i | tx_fb_i;
  assign err_set    = (|(req_i & SYS_GRP)) & ~sys_ok;

  // next state: each bit loads at its own path's boundary
  always_comb begin
    for (int i = 0; i < LB_N; i++) begin
      if (RX_GRP[i] ? rx_fb_i : tx_fb_i)
        act_d[i] = req_i[i] & legal_mask[i];
      else
        act_d[i] = act_q[i];
    end
    err_d = err_set | (err_q & ~err_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (act_en) begin
      act_q <= act_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign act_o      = act_q & legal_mask;
  assign sys_ok_o   = sys_ok;
  assign err_o      = err_q;
  assign conflict_o = act_o[LB_PAY] & act_o[LB_SLOC];
endmodule

// File: rtl/lbk_mux.sv
module lbk_mux #(
  parameter int W = 10
) (
  input  logic         sel_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  assign y_o = sel_i ? b_i : a_i;
endmodule

// File: rtl/lbk_steer.sv
module lbk_steer
  import lbk_pkg::*;
(
  input  logic en_i,
  input  logic rx_master_i,
  input  logic tx_master_i,
  input  logic rx_sck_i,
  input  logic rx_sfs_i,
  input  logic tx_sck_i,
  input  logic tx_sfs_i,
  output logic rx_sck_o,
  output logic rx_sfs_o,
  output logic tx_sck_o,
  output logic tx_sfs_o
);
  steer_e dir;

  always_comb begin
    dir = STEER_NONE;
    if (en_i && rx_master_i && !tx_master_i)      dir = STEER_RX2TX;
    else if (en_i && tx_master_i && !rx_master_i) dir = STEER_TX2RX;
  end

  always_comb begin
    rx_sck_o = rx_sck_i;
    rx_sfs_o = rx_sfs_i;
    tx_sck_o = tx_sck_i;
    tx_sfs_o = tx_sfs_i;
    unique case (dir)
      STEER_RX2TX: begin
        tx_sck_o = rx_sck_i;
        tx_sfs_o = rx_sfs_i;
      end
      STEER_TX2RX: begin
        rx_sck_o = tx_sck_i;
        rx_sfs_o = tx_sfs_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lbk_router.sv
module lbk_router
  import lbk_pkg::*;
#(
  parameter int DW = 8,
  parameter int GW = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LB_N-1:0]   req_i,
  input  logic              rx_fb_i,
  input  logic              tx_fb_i,
  input  logic              rx_master_i,
  input  logic              tx_master_i,
  input  logic              rx_mux_i,
  input  logic              tx_mux_i,
  input  logic              rx_e1r_i,
  input  logic              tx_e1r_i,
  input  logic              err_clr_i,
  input  logic [DW+GW:0]    es_i,
  input  logic [DW+GW:0]    tsys_i,
  input  logic [DW+GW:0]    line_rx_i,
  input  logic [DW+GW:0]    rja_q_i,
  input  logic [DW+GW:0]    tbuf_i,
  input  logic [DW+GW:0]    tja_q_i,
  output logic [DW+GW:0]    rsys_o,
  output logic [DW+GW:0]    tpc_o,
  output logic [DW+GW:0]    fp_o,
  output logic [DW+GW:0]    tja_d_o,
  output logic [DW+GW:0]    rja_d_o,
  input  logic              rx_sck_i,
  input  logic              rx_sfs_i,
  input  logic              tx_sck_i,
  input  logic              tx_sfs_i,
  output logic              rx_sck_o,
  output logic              rx_sfs_o,
  output logic              tx_sck_o,
  output logic              tx_sfs_o,
  output logic              sys_err_o,
  output logic              conflict_o
);
  localparam int SW = DW + GW + 1;
  localparam int NSTG = 4;

  logic [LB_N-1:0] act_w;
  logic            sys_ok_w;
  logic [SW-1:0]   stg_dflt [NSTG];
  logic [SW-1:0]   stg_alt  [NSTG];
  logic            stg_sel  [NSTG];
  logic [SW-1:0]   stg_y    [NSTG];
  logic [SW-1:0]   tpc_line;

  lbk_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .rx_fb_i    (rx_fb_i),
    .tx_fb_i    (tx_fb_i),
    .rx_master_i(rx_master_i),
    .tx_master_i(tx_master_i),
    .rx_mux_i   (rx_mux_i),
    .tx_mux_i   (tx_mux_i),
    .rx_e1r_i   (rx_e1r_i),
    .tx_e1r_i   (tx_e1r_i),
    .err_clr_i  (err_clr_i),
    .act_o      (act_w),
    .sys_ok_o   (sys_ok_w),
    .err_o      (sys_err_o),
    .conflict_o (conflict_o)
  );

  // single-source stages: default source, loopback source, enable
  always_comb begin
    stg_dflt[0] = es_i;      stg_alt[0] = tsys_i;  stg_sel[0] = act_w[LB_SRMT];
    stg_dflt[1] = rja_q_i;   stg_alt[1] = tbuf_i;  stg_sel[1] = act_w[LB_DIG1];
    stg_dflt[2] = tbuf_i;    stg_alt[2] = rja_q_i; stg_sel[2] = act_w[LB_REM];
    stg_dflt[3] = line_rx_i; stg_alt[3] = tja_q_i; stg_sel[3] = act_w[LB_DIG2];
  end

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    lbk_mux #(.W(SW)) u_mux (
      .sel_i(stg_sel[g]),
      .a_i  (stg_dflt[g]),
      .b_i  (stg_alt[g]),
      .y_o  (stg_y[g])
    );
  end

  assign rsys_o  = stg_y[0];
  assign fp_o    = stg_y[1];
  assign tja_d_o = stg_y[2];
  assign rja_d_o = stg_y[3];

  // transmit payload input: payload loopback first, system local last
  lbk_mux #(.W(SW)) u_tpc_pay (
    .sel_i(act_w[LB_PAY]),
    .a_i  (tsys_i),
    .b_i  (es_i),
    .y_o  (tpc_line)
  );

  lbk_mux #(.W(SW)) u_tpc_sys (
    .sel_i(act_w[LB_SLOC]),
    .a_i  (tpc_line),
    .b_i  (es_i),
    .y_o  (tpc_o)
  );

  lbk_steer u_steer (
    .en_i       (act_w[LB_SRMT] | act_w[LB_SLOC]),
    .rx_master_i(rx_master_i),
    .tx_master_i(tx_master_i),
    .rx_sck_i   (rx_sck_i),
    .rx_sfs_i   (rx_sfs_i),
    .tx_sck_i   (tx_sck_i),
    .tx_sfs_i   (tx_sfs_i),
    .rx_sck_o   (rx_sck_o),
    .rx_sfs_o   (rx_sfs_o),
    .tx_sck_o   (tx_sck_o),
    .tx_sfs_o   (tx_sfs_o)
  );
endmodule

// File: rtl/lbk_router_chk.sv
module lbk_router_chk #(
  parameter int SW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [5:0]    req_i,
  input logic [5:0]    act,
  input logic          rx_fb_i,
  input logic          tx_fb_i,
  input logic          rx_master_i,
  input logic          tx_master_i,
  input logic          rx_mux_i,
  input logic          tx_mux_i,
  input logic          rx_e1r_i,
  input logic          tx_e1r_i,
  input logic          err_clr_i,
  input logic          sys_err_o,
  input logic          conflict_o,
  input logic [SW-1:0] es_i,
  input logic [SW-1:0] rja_q_i,
  input logic [SW-1:0] rsys_o,
  input logic [SW-1:0] tpc_o,
  input logic [SW-1:0] tja_d_o,
  input logic          rx_sck_i,
  input logic          tx_sck_o
);
  logic mode_ok;
  assign mode_ok = !rx_mux_i && !tx_mux_i && (rx_master_i != tx_master_i)
                && !rx_e1r_i && !tx_e1r_i;

  // R4: illegal mode never lets transmit data reach the receive system side
  p_sys_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ok |-> (rsys_o == es_i));

  // R5: the error bit holds without a clear
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_err_o && !err_clr_i) |=> sys_err_o);

  // R5: illegal request sets the error bit
  p_err_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|req_i[1:0]) && !mode_ok) |=> sys_err_o);

  // R11: receive-group enables hold without a receive boundary
  p_rx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_fb_i |=> ({act[5], act[3], act[0]} == $past({act[5], act[3], act[0]}))
                 || !mode_ok || $past(!mode_ok));

  // R11: transmit-group enables hold without a transmit boundary
  p_tx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_fb_i |=> ({act[4], act[2], act[1]} == $past({act[4], act[2], act[1]}))
                 || !mode_ok || $past(!mode_ok));

  // R12: a conflict resolves to the receive stream
  p_conflict_r12: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_o |-> (tpc_o == es_i));

  // R9: remote loopback feeds the transmit attenuator from the receive one
  p_remote_r9: assert property (@(posedge clk) disable iff (!rst_n)
    act[4] |-> (tja_d_o == rja_q_i));

  // R6: receive master drives the transmit clock during system loopback
  p_steer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((act[0] || act[1]) && rx_master_i && !tx_master_i) |-> (tx_sck_o == rx_sck_i));
endmodule

bind lbk_router lbk_router_chk #(.SW(DW + GW + 1)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .act        (act_w),
  .rx_fb_i    (rx_fb_i),
  .tx_fb_i    (tx_fb_i),
  .rx_master_i(rx_master_i),
  .tx_master_i(tx_master_i),
  .rx_mux_i   (rx_mux_i),
  .tx_mux_i   (tx_mux_i),
  .rx_e1r_i   (rx_e1r_i),
  .tx_e1r_i   (tx_e1r_i),
  .err_clr_i  (err_clr_i),
  .sys_err_o  (sys_err_o),
  .conflict_o (conflict_o),
  .es_i       (es_i),
  .rja_q_i    (rja_q_i),
  .rsys_o     (rsys_o),
  .tpc_o      (tpc_o),
  .tja_d_o    (tja_d_o),
  .rx_sck_i   (rx_sck_i),
  .tx_sck_o   (tx_sck_o)
);

// File: tb/tb_lbk_router.sv
module tb_lbk_router;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int DW = 8;
  localparam int GW = 1;
  localparam int SW = DW + GW + 1;

  localparam logic [SW-1:0] V_ES   = 10'h2A1;
  localparam logic [SW-1:0] V_TSYS = 10'h155;
  localparam logic [SW-1:0] V_LINE = 10'h0F3;
  localparam logic [SW-1:0] V_RJA  = 10'h3C8;
  localparam logic [SW-1:0] V_TBUF = 10'h266;
  localparam logic [SW-1:0] V_TJA  = 10'h11E;

  logic clk, rst_n;
  logic [5:0] req_i;
  logic rx_fb_i, tx_fb_i, rx_master_i, tx_master_i, rx_mux_i, tx_mux_i;
  logic rx_e1r_i, tx_e1r_i, err_clr_i;
  logic [SW-1:0] es_i, tsys_i, line_rx_i, rja_q_i, tbuf_i, tja_q_i;
  logic [SW-1:0] rsys_o, tpc_o, fp_o, tja_d_o, rja_d_o;
  logic rx_sck_i, rx_sfs_i, tx_sck_i, tx_sfs_i;
  logic rx_sck_o, rx_sfs_o, tx_sck_o, tx_sfs_o, sys_err_o, conflict_o;

  int n_run = 0;
  int n_fail = 0;

  lbk_router #(.DW(DW), .GW(GW)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .rx_fb_i(rx_fb_i), .tx_fb_i(tx_fb_i),
    .rx_master_i(rx_master_i), .tx_master_i(tx_master_i),
    .rx_mux_i(rx_mux_i), .tx_mux_i(tx_mux_i),
    .rx_e1r_i(rx_e1r_i), .tx_e1r_i(tx_e1r_i), .err_clr_i(err_clr_i),
    .es_i(es_i), .tsys_i(tsys_i), .line_rx_i(line_rx_i), .rja_q_i(rja_q_i),
    .tbuf_i(tbuf_i), .tja_q_i(tja_q_i),
    .rsys_o(rsys_o), .tpc_o(tpc_o), .fp_o(fp_o), .tja_d_o(tja_d_o), .rja_d_o(rja_d_o),
    .rx_sck_i(rx_sck_i), .rx_sfs_i(rx_sfs_i), .tx_sck_i(tx_sck_i), .tx_sfs_i(tx_sfs_i),
    .rx_sck_o(rx_sck_o), .rx_sfs_o(rx_sfs_o), .tx_sck_o(tx_sck_o), .tx_sfs_o(tx_sfs_o),
    .sys_err_o(sys_err_o), .conflict_o(conflict_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    #(200000 * 5);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive request and strobes before an edge, sample just after it
  task automatic apply(input logic [5:0] r, input logic rf, input logic tf);
    @(negedge clk);
    req_i = r; rx_fb_i = rf; tx_fb_i = tf;
    @(posedge clk); #1;
    rx_fb_i = 1'b0; tx_fb_i = 1'b0;
  endtask

  task automatic legal_mode(input logic rxm);
    @(negedge clk);
    rx_master_i = rxm; tx_master_i = ~rxm;
    rx_mux_i = 0; tx_mux_i = 0; rx_e1r_i = 0; tx_e1r_i = 0;
  endtask

  task automatic clear_all();
    apply(6'b0, 1'b1, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1 rsys", rsys_o, V_ES);
    chk("R1 tpc", tpc_o, V_TSYS);
    chk("R1 fp", fp_o, V_RJA);
    chk("R1 tja_d", tja_d_o, V_TBUF);
    chk("R1 rja_d", rja_d_o, V_LINE);
    chk("R1 err", sys_err_o, 0);
    chk("R1 conflict", conflict_o, 0);
  endtask

  task automatic t_sys_remote();
    legal_mode(1'b1);
    apply(6'b000001, 1'b0, 1'b1);            // wrong boundary
    chk("R11 srmt held off", rsys_o, V_ES);
    apply(6'b000001, 1'b1, 1'b0);
    chk("R2 rsys", rsys_o, V_TSYS);
    chk("R2 tpc kept", tpc_o, V_TSYS);
    @(negedge clk); rx_sck_i = 1; rx_sfs_i = 1; tx_sck_i = 0; tx_sfs_i = 0; #1;
    chk("R6 tx_sck from rx", tx_sck_o, 1);
    chk("R6 tx_sfs from rx", tx_sfs_o, 1);
    chk("R6 rx_sck own", rx_sck_o, 1);
    clear_all();
    chk("R6 no steer idle", tx_sck_o, 0);
    chk("R2 released", rsys_o, V_ES);
  endtask

  task automatic t_sys_remote_txm();
    legal_mode(1'b0);
    apply(6'b000001, 1'b1, 1'b0);
    @(negedge clk); rx_sck_i = 0; rx_sfs_i = 0; tx_sck_i = 1; tx_sfs_i = 1; #1;
    chk("R6 rx_sck from tx", rx_sck_o, 1);
    chk("R6 rx_sfs from tx", rx_sfs_o, 1);
    chk("R2 rsys txm", rsys_o, V_TSYS);
    clear_all();
    @(negedge clk); tx_sck_i = 0; tx_sfs_i = 0;
  endtask

  task automatic t_sys_local();
    legal_mode(1'b1);
    apply(6'b000010, 1'b1, 1'b0);            // wrong boundary
    chk("R11 sloc held off", tpc_o, V_TSYS);
    apply(6'b000010, 1'b0, 1'b1);
    chk("R3 tpc", tpc_o, V_ES);
    chk("R3 rsys kept", rsys_o, V_ES);
    clear_all();
  endtask

  task automatic t_illegal();
    legal_mode(1'b1);
    @(negedge clk); rx_mux_i = 1;
    apply(6'b000001, 1'b1, 1'b1);
    chk("R4 mux ignored", rsys_o, V_TSYS ^ V_TSYS ^ V_ES);
    chk("R5 err set", sys_err_o, 1);
    apply(6'b000000, 1'b0, 1'b0);
    legal_mode(1'b1);
    apply(6'b000000, 1'b0, 1'b0);
    chk("R5 err sticky", sys_err_o, 1);
    @(negedge clk); err_clr_i = 1;
    @(posedge clk); #1; err_clr_i = 0;
    chk("R5 err cleared", sys_err_o, 0);
    // both master
    @(negedge clk); tx_master_i = 1;
    apply(6'b000010, 1'b1, 1'b1);
    chk("R4 two masters ignored", tpc_o, V_TSYS);
    chk("R5 err two masters", sys_err_o, 1);
    // E1-rate framing on transmit
    legal_mode(1'b1);
    @(negedge clk); tx_e1r_i = 1; err_clr_i = 1;
    apply(6'b000001, 1'b1, 1'b1);
    err_clr_i = 0;
    chk("R4 e1 rate ignored", rsys_o, V_ES);
    chk("R5 set wins over clear", sys_err_o, 1);
    apply(6'b000000, 1'b1, 1'b1);
    @(negedge clk); err_clr_i = 1;
    @(posedge clk); #1; err_clr_i = 0;
    legal_mode(1'b1);
  endtask

  task automatic t_payload();
    apply(6'b000100, 1'b0, 1'b1);
    chk("R7 tpc", tpc_o, V_ES);
    chk("R7 rsys kept", rsys_o, V_ES);
    clear_all();
  endtask

  task automatic t_dig1();
    apply(6'b001000, 1'b0, 1'b1);            // wrong boundary
    chk("R11 dig1 held off", fp_o, V_RJA);
    apply(6'b001000, 1'b1, 1'b0);
    chk("R8 fp", fp_o, V_TBUF);
    chk("R8 tja_d kept", tja_d_o, V_TBUF);
    clear_all();
  endtask

  task automatic t_remote();
    apply(6'b010000, 1'b1, 1'b0);            // wrong boundary
    chk("R11 rem held off", tja_d_o, V_TBUF);
    apply(6'b010000, 1'b0, 1'b1);
    chk("R9 tja_d", tja_d_o, V_RJA);
    chk("R9 fp kept", fp_o, V_RJA);
    clear_all();
  endtask

  task automatic t_dig2();
    apply(6'b100000, 1'b1, 1'b0);
    chk("R10 rja_d", rja_d_o, V_TJA);
    chk("R10 tja_d kept", tja_d_o, V_TBUF);
    apply(6'b000000, 1'b0, 1'b1);            // wrong boundary for release
    chk("R11 dig2 holds", rja_d_o, V_TJA);
    clear_all();
    chk("R10 released", rja_d_o, V_LINE);
  endtask

  task automatic t_conflict();
    legal_mode(1'b1);
    apply(6'b000110, 1'b0, 1'b1);
    chk("R12 conflict", conflict_o, 1);
    chk("R12 tpc", tpc_o, V_ES);
    apply(6'b000100, 1'b0, 1'b1);
    chk("R12 single no conflict", conflict_o, 0);
    clear_all();
  endtask

  initial begin
    rst_n = 0; req_i = '0; rx_fb_i = 0; tx_fb_i = 0;
    rx_master_i = 1; tx_master_i = 0; rx_mux_i = 0; tx_mux_i = 0;
    rx_e1r_i = 0; tx_e1r_i = 0; err_clr_i = 0;
    es_i = V_ES; tsys_i = V_TSYS; line_rx_i = V_LINE;
    rja_q_i = V_RJA; tbuf_i = V_TBUF; tja_q_i = V_TJA;
    rx_sck_i = 0; rx_sfs_i = 0; tx_sck_i = 0; tx_sfs_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_sys_remote();
    t_sys_remote_txm();
    t_sys_local();
    t_illegal();
    t_payload();
    t_dig1();
    t_remote();
    t_dig2();
    t_conflict();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule